// File: doc/BRIEF.md
# Partition Label Selector

This block sits beside a processor's memory request path and decides which partition identifier travels with each outgoing request. It holds a hypervisor-owned partition control register and a small table that maps virtual partition numbers to physical ones. On every cycle it looks at the current exception level, whether the hypervisor level is enabled, the host-mode controls E2H and TGE, and whether the request is an instruction fetch. From these it picks one of two label registers, the user-level one or the kernel-level one, and picks its instruction or data field. It then either passes that value through as physical or uses it as an index into the mapping table.

Software writes the control register and the table entries through a simple write port: one strobe, a target select, an entry index and a 64-bit data word. The label output is combinational from the current inputs and the registered state. Each cycle, the selection logic settles into one of five named source modes. MODE_EL0_DIRECT and MODE_EL0_MAPPED use the user-level register. MODE_EL1_DIRECT and MODE_EL1_MAPPED use the kernel-level register. MODE_HIGH_DIRECT applies at levels 2 and 3. There are no sequential transitions between modes. The mode follows the inputs in the same cycle.

Top module: `partid_label_sel`

## Requirements
- R1: After reset the control register reads all zeros and every mapping table entry holds zero.
- R2: A control write (wr_tbl=0) keeps only bit 31 (trap enable), bit 8 (user-level lock), bit 1 (kernel-level map enable) and bit 0 (user-level map enable). Every other bit reads back as zero.
- R3: The control register keeps its value in any cycle without a control write, including cycles that write the table.
- R4: At level 1 the kernel-level register is the source. Its ID is translated when bit 1 is set and the hypervisor level is enabled.
- R5: At level 0, with the hypervisor level enabled, TGE=0 and bit 8 set, the kernel-level register is the source. In that case bit 1, and not bit 0, decides translation.
- R6: At level 0, when bit 8 is clear, the hypervisor level is disabled, or TGE=1, the user-level register is the source, and bit 0 decides translation.
- R7: When E2H=1 and TGE=1 at level 0, bit 0 is ignored and the user-level ID passes through as physical.
- R8: When the hypervisor level is disabled, the whole control register has no effect and every ID is physical.
- R9: An instruction fetch (is_ifetch=1) uses the instruction field of the chosen register. Any other access uses the data field.
- R10: A virtual ID below 8 selects the table entry of that number. A virtual ID of 8 or more selects entry 0.
- R11: At levels 2 and 3 the kernel-level register's ID is used as physical, without translation.
- R12: label_virt is 1 exactly when label_pid came from the table. Otherwise label_pid equals the selected raw ID.
- R13: A table write (wr_tbl=1) stores wr_data[15:0] in the entry numbered wr_idx and leaves the other entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_tbl | input | 1 | 1 writes the mapping table, 0 writes the control register |
| wr_idx | input | 3 | Table entry number for table writes |
| wr_data | input | 64 | Write data |
| ctrl_rd | output | 64 | Current control register value |
| cur_el | input | 2 | Current exception level, 0 to 3 |
| el2_en | input | 1 | Hypervisor level enabled in the current security state |
| hcr_e2h | input | 1 | Effective host-mode E2H control |
| hcr_tge | input | 1 | Effective host-mode TGE control |
| is_ifetch | input | 1 | Request is an instruction fetch |
| el0_pid_i | input | 16 | User-level register, instruction partition ID |
| el0_pid_d | input | 16 | User-level register, data partition ID |
| el1_pid_i | input | 16 | Kernel-level register, instruction partition ID |
| el1_pid_d | input | 16 | Kernel-level register, data partition ID |
| label_pid | output | 16 | Physical partition ID for the request |
| label_virt | output | 1 | label_pid was produced by table translation |

## Verification
The assertions assume that the inputs are stable, known values at each rising edge, and that E2H and TGE arrive already reduced to their effective values. The checks that compare the label with the raw ID also assume that the label inputs do not change between the settle point and the edge. The bench drives every input on the falling edge and holds it for at least a full cycle. It samples the combinational label one nanosecond after that edge, so each check sees one settled input set.

// File: rtl/plsel_pkg.sv
package plsel_pkg;
    localparam int CTRL_W      = 64;
    localparam int BIT_TRAP    = 31;
    localparam int BIT_LOCK    = 8;
    localparam int BIT_K_MAP   = 1;
    localparam int BIT_U_MAP   = 0;

    localparam logic [CTRL_W-1:0] CTRL_MASK =
        (CTRL_W'(1) << BIT_TRAP) | (CTRL_W'(1) << BIT_LOCK) |
        (CTRL_W'(1) << BIT_K_MAP) | (CTRL_W'(1) << BIT_U_MAP);

    typedef enum logic [2:0] {
        MODE_EL0_DIRECT  = 3'd0,
        MODE_EL0_MAPPED  = 3'd1,
        MODE_EL1_DIRECT  = 3'd2,
        MODE_EL1_MAPPED  = 3'd3,
        MODE_HIGH_DIRECT = 3'd4
    } src_mode_t;

    typedef struct packed {
        logic trap;
        logic lock;
        logic k_map;
        logic u_map;
    } ctrl_bits_t;
endpackage

// File: rtl/plsel_ctrl_reg.sv
module plsel_ctrl_reg
    import plsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output ctrl_bits_t        bits
);
    logic [CTRL_W-1:0] reg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (we) begin
            reg_q <= wdata & CTRL_MASK;
        end
    end

    always_comb begin
        rdata      = reg_q;
        bits.trap  = reg_q[BIT_TRAP];
        bits.lock  = reg_q[BIT_LOCK];
        bits.k_map = reg_q[BIT_K_MAP];
        bits.u_map = reg_q[BIT_U_MAP];
    end

    // R3: value holds without a control write
    p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rdata));
endmodule

// File: rtl/plsel_vmap.sv
module plsel_vmap #(
    parameter int PID_W     = 16,
    parameter int MAP_DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [$clog2(MAP_DEPTH)-1:0] widx,
    input  logic [PID_W-1:0]             wdata,
    input  logic [PID_W-1:0]             vid,
    output logic [PID_W-1:0]             pid
);
    localparam int IDX_W = $clog2(MAP_DEPTH);
    localparam logic [PID_W-1:0] DEPTH_V = PID_W'(MAP_DEPTH);

    logic [PID_W-1:0] ent [MAP_DEPTH];
    logic [IDX_W-1:0] ridx;
    logic             in_range;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < MAP_DEPTH; k++) ent[k] <= '0;
        end else if (we) begin
            for (int k = 0; k < MAP_DEPTH; k++) begin
                if (widx == IDX_W'(k)) ent[k] <= wdata;
            end
        end
    end

    always_comb begin
        in_range = (vid < DEPTH_V);
        ridx     = in_range ? vid[IDX_W-1:0] : '0;
        pid      = ent[ridx];
    end

    // R10: out-of-range virtual IDs read entry 0
    p_oor_entry0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> pid == ent[0]);
endmodule

// File: rtl/plsel_route.sv
module plsel_route
    import plsel_pkg::*;
#(
    parameter int PID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cur_el,
    input  logic             el2_en,
    input  logic             e2h,
    input  logic             tge,
    input  logic             is_ifetch,
    input  ctrl_bits_t       bits,
    input  logic [PID_W-1:0] u_pid_i,
    input  logic [PID_W-1:0] u_pid_d,
    input  logic [PID_W-1:0] k_pid_i,
    input  logic [PID_W-1:0] k_pid_d,
    output src_mode_t        mode,
    output logic [PID_W-1:0] raw_pid,
    output logic             want_map
);
    logic u_locked;
    logic u_host;

    always_comb begin
        u_locked = el2_en && !tge && bits.lock;
        u_host   = e2h && tge;
        mode     = MODE_EL0_DIRECT;
        unique case (cur_el)
            2'd0: begin
                if (u_locked)
                    mode = bits.k_map ? MODE_EL1_MAPPED : MODE_EL1_DIRECT;
                else if (el2_en && !u_host && bits.u_map)
                    mode = MODE_EL0_MAPPED;
                else
                    mode = MODE_EL0_DIRECT;
            end
            2'd1: mode = (el2_en && bits.k_map) ? MODE_EL1_MAPPED
                                                : MODE_EL1_DIRECT;
            2'd2,
            2'd3: mode = MODE_HIGH_DIRECT;
            default: mode = MODE_EL0_DIRECT;
        endcase
    end

    always_comb begin
        raw_pid  = '0;
        want_map = 1'b0;
        unique case (mode)
            MODE_EL0_DIRECT: raw_pid = is_ifetch ? u_pid_i : u_pid_d;
            MODE_EL0_MAPPED: begin
                raw_pid  = is_ifetch ? u_pid_i : u_pid_d;
                want_map = 1'b1;
            end
            MODE_EL1_DIRECT,
            MODE_HIGH_DIRECT: raw_pid = is_ifetch ? k_pid_i : k_pid_d;
            MODE_EL1_MAPPED: begin
                raw_pid  = is_ifetch ? k_pid_i : k_pid_d;
                want_map = 1'b1;
            end
            default: raw_pid = '0;
        endcase
    end

    // R11: upper levels never translate
    p_high_direct_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cur_el[1] |-> !want_map);
    // R8: no translation without the hypervisor level
    p_no_el2_phys_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !el2_en |-> !want_map);
    // R7: host mode keeps user IDs physical at level 0
    p_host_u_phys_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_el == 2'd0 && e2h && tge) |-> mode == MODE_EL0_DIRECT);
endmodule

// File: rtl/partid_label_sel.sv
module partid_label_sel
    import plsel_pkg::*;
#(
    parameter int PID_W     = 16,
    parameter int MAP_DEPTH = 8,
    parameter int IDX_W     = $clog2(MAP_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_tbl,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [63:0]       wr_data,
    output logic [63:0]       ctrl_rd,
    input  logic [1:0]        cur_el,
    input  logic              el2_en,
    input  logic              hcr_e2h,
    input  logic              hcr_tge,
    input  logic              is_ifetch,
    input  logic [PID_W-1:0]  el0_pid_i,
    input  logic [PID_W-1:0]  el0_pid_d,
    input  logic [PID_W-1:0]  el1_pid_i,
    input  logic [PID_W-1:0]  el1_pid_d,
    output logic [PID_W-1:0]  label_pid,
    output logic              label_virt
);
    ctrl_bits_t       bits;
    src_mode_t        mode;
    logic [PID_W-1:0] raw_pid;
    logic [PID_W-1:0] mapped_pid;
    logic             want_map;

    plsel_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && !wr_tbl),
        .wdata (wr_data),
        .rdata (ctrl_rd),
        .bits  (bits)
    );

    plsel_route #(.PID_W(PID_W)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_el    (cur_el),
        .el2_en    (el2_en),
        .e2h       (hcr_e2h),
        .tge       (hcr_tge),
        .is_ifetch (is_ifetch),
        .bits      (bits),
        .u_pid_i   (el0_pid_i),
        .u_pid_d   (el0_pid_d),
        .k_pid_i   (el1_pid_i),
        .k_pid_d   (el1_pid_d),
        .mode      (mode),
        .raw_pid   (raw_pid),
        .want_map  (want_map)
    );

    plsel_vmap #(.PID_W(PID_W), .MAP_DEPTH(MAP_DEPTH)) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && wr_tbl),
        .widx  (wr_idx),
        .wdata (wr_data[PID_W-1:0]),
        .vid   (raw_pid),
        .pid   (mapped_pid)
    );

    always_comb begin
        label_virt = want_map;
        label_pid  = want_map ? mapped_pid : raw_pid;
    end

    // R12: untranslated label equals the selected raw ID
    p_phys_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !label_virt |-> label_pid == raw_pid);
    // R1: control register is clear right after reset release
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ctrl_rd == '0);
    // R2: reserved control bits never read back as one
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_tbl) |=> (ctrl_rd & ~CTRL_MASK) == '0);
endmodule

// File: tb/sim_partid_label_sel.sv
`timescale 1ns/1ps
module sim_partid_label_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_tbl = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] ctrl_rd;
    logic [1:0]  cur_el = '0;
    logic        el2_en = 1'b1, hcr_e2h = 1'b0, hcr_tge = 1'b0, is_ifetch = 1'b0;
    logic [15:0] el0_pid_i = '0, el0_pid_d = '0, el1_pid_i = '0, el1_pid_d = '0;
    logic [15:0] label_pid;
    logic        label_virt;

    int total = 0;
    int bad = 0;
    logic [15:0] shadow [8];

    always #2.5 clk = ~clk;

    partid_label_sel u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tbl(wr_tbl),
        .wr_idx(wr_idx), .wr_data(wr_data), .ctrl_rd(ctrl_rd),
        .cur_el(cur_el), .el2_en(el2_en), .hcr_e2h(hcr_e2h),
        .hcr_tge(hcr_tge), .is_ifetch(is_ifetch),
        .el0_pid_i(el0_pid_i), .el0_pid_d(el0_pid_d),
        .el1_pid_i(el1_pid_i), .el1_pid_d(el1_pid_d),
        .label_pid(label_pid), .label_virt(label_virt)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_ctrl(input logic [63:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_tbl = 1'b0; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put_map(input int idx, input logic [63:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_tbl = 1'b1; wr_idx = 3'(idx); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        shadow[idx] = v[15:0];
    endtask

    task automatic req(input logic [1:0] el, input logic e2, input logic e2h,
                       input logic tge, input logic ifx);
        @(negedge clk);
        cur_el = el; el2_en = e2; hcr_e2h = e2h; hcr_tge = tge; is_ifetch = ifx;
        #1;
    endtask

    function automatic logic [15:0] lookup(input logic [15:0] v);
        return (v < 16'd8) ? shadow[v[2:0]] : shadow[0];
    endfunction

    task automatic t_reset();
        chk("R1 ctrl after reset", ctrl_rd, 64'h0);
        put_ctrl(64'h2);
        el1_pid_d = 16'd3;
        req(2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R1 table entry zero", label_pid, 16'h0);
        chk("R12 virt flag set", label_virt, 1'b1);
    endtask

    task automatic t_ctrl();
        put_ctrl(64'hFFFF_FFFF_FFFF_FFFF);
        chk("R2 write mask", ctrl_rd, 64'h0000_0000_8000_0103);
        put_map(3, 64'hFFFF_FFFF_FFFF_1234);
        repeat (3) @(negedge clk);
        #1;
        chk("R3 ctrl holds over table write", ctrl_rd, 64'h0000_0000_8000_0103);
        put_ctrl(64'h0);
        chk("R2 clear", ctrl_rd, 64'h0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 8; i++) put_map(i, 64'hABCD_0000_0000_1000 + 64'(i * 16'h111));
        put_ctrl(64'h2);
        for (int i = 0; i < 8; i++) begin
            el1_pid_d = 16'(i);
            req(2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
            chk("R13 entry content", label_pid, 16'h1000 + 16'(i * 16'h111));
        end
    endtask

    task automatic t_el1();
        put_ctrl(64'h2);
        el1_pid_i = 16'd2; el1_pid_d = 16'd5;
        req(2'd1, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R9 R4 fetch mapped", label_pid, shadow[2]);
        req(2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R9 R4 data mapped", label_pid, shadow[5]);
        put_ctrl(64'h1);
        #1;
        chk("R4 bit1 clear raw", label_pid, 16'd5);
        chk("R12 flag clear", label_virt, 1'b0);
    endtask

    task automatic t_lock();
        el0_pid_d = 16'd1; el1_pid_d = 16'd6;
        put_ctrl(64'h102);
        req(2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5 lock kernel mapped", label_pid, shadow[6]);
        put_ctrl(64'h101);
        #1;
        chk("R5 lock ignores bit0", label_pid, 16'd6);
    endtask

    task automatic t_el0();
        el0_pid_i = 16'd4; el0_pid_d = 16'd7; el1_pid_d = 16'd6;
        put_ctrl(64'h001);
        req(2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R6 user mapped", label_pid, shadow[7]);
        req(2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R6 R9 user fetch mapped", label_pid, shadow[4]);
        put_ctrl(64'h103);
        req(2'd0, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R6 tge breaks lock", label_pid, shadow[7]);
        put_ctrl(64'h000);
        req(2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R6 user raw", label_pid, 16'd7);
    endtask

    task automatic t_host();
        el0_pid_d = 16'd3;
        put_ctrl(64'h103);
        req(2'd0, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R7 host user raw", label_pid, 16'd3);
        chk("R7 host flag", label_virt, 1'b0);
        req(2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R7 e2h alone no effect", label_pid, shadow[6]);
    endtask

    task automatic t_noel2();
        el0_pid_d = 16'd2; el1_pid_d = 16'd5;
        put_ctrl(64'h103);
        req(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 user raw", label_pid, 16'd2);
        req(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 kernel raw", label_pid, 16'd5);
        chk("R8 flag", label_virt, 1'b0);
    endtask

    task automatic t_range();
        put_ctrl(64'h2);
        el1_pid_d = 16'd8;
        req(2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10 id 8 entry0", label_pid, lookup(16'd8));
        el1_pid_d = 16'hFFFF;
        #1;
        chk("R10 id max entry0", label_pid, shadow[0]);
        el1_pid_d = 16'd7;
        #1;
        chk("R10 id 7", label_pid, shadow[7]);
    endtask

    task automatic t_high();
        put_ctrl(64'h103);
        el1_pid_i = 16'd6; el1_pid_d = 16'd4;
        req(2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R11 level2 raw", label_pid, 16'd4);
        req(2'd3, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R11 level3 fetch raw", label_pid, 16'd6);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_ctrl();
        t_fill();
        t_el1();
        t_lock();
        t_el0();
        t_host();
        t_noel2();
        t_range();
        t_high();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule